// File: doc/BRIEF.md
# Calibration Byte Read Sequencer

This host-side block fetches the oscillator calibration byte from a target held in its parallel programming mode. A start pulse launches a fixed script of four steps. The first step places the command value 0x08 on the shared data bus and strobes it in as a command. The second step places 0x00 on the bus and strobes it in as the low address byte. The block then releases the bus, pulls the active-low read enable down with byte select high, and samples the target's reply. The last step raises read enable again.

Every step has a length set by a parameter: bus setup before a strobe, hold after it, the turnaround gap before the target may drive, and the capture delay after read enable falls. The captured byte leaves the block on a valid/ready port. `res_valid` rises in the same cycle as the one-cycle `done` pulse. While `res_valid` is high and `res_ready` is low, `res_data` stays frozen. The result is consumed in the cycle where both are high. A new sequence can start only once the result has been taken, so a consumer that is not ready also holds off new reads.

Top module: `calib_read_seq`

## Requirements
- R1: After reset and while idle: `ld_pulse`=0, `rd_en_n`=1, `bus_oe`=0, `busy`=0, `done`=0, `res_valid`=0, `act_sel`=2'b00, `byte_sel`=0, `bus_out`=0x00.
- R2: The command step drives `bus_oe`=1, `bus_out`=0x08, `act_sel`=2'b10 and `byte_sel`=0. These values appear SETUP_CYC cycles before a one-cycle `ld_pulse`, and stay for HOLD_CYC cycles after it. The step begins in the cycle after start is accepted.
- R3: The address step follows the command hold at once. It drives `bus_oe`=1, `bus_out`=0x00, `act_sel`=2'b00 and `byte_sel`=0, with the same setup, strobe and hold timing as R2.
- R4: After the address hold, `bus_oe` drops to 0 for GAP_CYC cycles with `rd_en_n` still 1. `bus_oe` is never 1 while `rd_en_n` is 0.
- R5: The read step holds `rd_en_n`=0 and `byte_sel`=1 for CAP_DLY cycles. `bus_in` is sampled at the CAP_DLY-th rising edge after `rd_en_n` fell, and `rd_en_n` is 1 again in the next cycle.
- R6: `done` is high for exactly one cycle, the cycle after capture. `busy` is high from the cycle after start is accepted through the `done` cycle, and low otherwise.
- R7: A start pulse while `busy` is high has no effect on the running sequence.
- R8: `res_valid` rises with `done` and `res_data` equals the sampled byte. While `res_valid`=1 and `res_ready`=0, both stay unchanged. The pair clears after a cycle with `res_ready`=1.
- R9: A start pulse while `res_valid`=1 is ignored.
- R10: Each sequence gives exactly two `ld_pulse` cycles, each with `bus_oe`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a sequence (accepted only when idle with no pending result) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| res_valid | output | 1 | Captured byte available |
| res_ready | input | 1 | Consumer accepts the byte |
| res_data | output | 8 | Captured calibration byte |
| act_sel | output | 2 | Load action select: 2'b10 command, 2'b00 address |
| byte_sel | output | 1 | Byte select; 1 during the read |
| ld_pulse | output | 1 | One-cycle load strobe |
| rd_en_n | output | 1 | Active-low read (output) enable for the target |
| bus_out | output | 8 | Data driven toward the target |
| bus_oe | output | 1 | Enable for the block's bus driver |
| bus_in | input | 8 | Data returned by the target |

## Verification
On every cycle, the assertions watch that the strobe is a single cycle wide and always lands on a driven bus, and that the bus driver was off in the cycle before read enable falls. They also check that `done` is a lone pulse with read enable high, and that a stalled result neither changes nor vanishes. The exact ordering and length of each step, the bus values and select codes at each strobe, and the capture instant can only be shown by the bench's cycle-by-cycle traces. The bench's target model returns a wrong byte for the first read cycles. The bench also shows that stray start pulses, during a run or while a result waits, are ignored.

// File: rtl/calseq_pkg.sv
package calseq_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_CSET, ST_CSTB, ST_CHLD,
    ST_ASET, ST_ASTB, ST_AHLD, ST_GAP, ST_READ, ST_FIN
  } seq_state_e;

  localparam logic [7:0] CMD_READ_CAL = 8'h08;
  localparam logic [7:0] ADDR_CAL_LO  = 8'h00;
  localparam logic [1:0] ACT_CMD      = 2'b10;
  localparam logic [1:0] ACT_ADDR     = 2'b00;
  localparam logic [1:0] ACT_NONE     = 2'b00;

  function automatic int unsigned max_of4(int unsigned a, int unsigned b,
                                          int unsigned c, int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/step_timer.sv
module step_timer #(
  parameter int unsigned TW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          zero
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/cal_result.sv
module cal_result #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap,
  input  logic [DW-1:0] cap_data,
  input  logic          res_ready,
  output logic          res_valid,
  output logic [DW-1:0] res_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
    end else if (cap) begin
      res_valid <= 1'b1;
      res_data  <= cap_data;
    end else if (res_valid && res_ready) begin
      res_valid <= 1'b0;
    end
  end

  // R8: a stalled result keeps its value and stays offered
  a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data)));
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import calseq_pkg::*;
#(
  parameter int unsigned SETUP_CYC = 1,
  parameter int unsigned HOLD_CYC  = 1,
  parameter int unsigned GAP_CYC   = 1,
  parameter int unsigned CAP_DLY   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_ok,
  output logic       busy,
  output logic       done,
  output logic       cap,
  output logic [1:0] act_sel,
  output logic       byte_sel,
  output logic       ld_pulse,
  output logic       rd_en_n,
  output logic [7:0] bus_out,
  output logic       bus_oe
);
  localparam int unsigned MAXN = max_of4(SETUP_CYC, HOLD_CYC, GAP_CYC, CAP_DLY);
  localparam int unsigned TW   = (MAXN < 2) ? 1 : $clog2(MAXN);

  localparam logic [TW-1:0] L_SETUP = TW'(SETUP_CYC - 1);
  localparam logic [TW-1:0] L_HOLD  = TW'(HOLD_CYC - 1);
  localparam logic [TW-1:0] L_GAP   = TW'(GAP_CYC - 1);
  localparam logic [TW-1:0] L_CAP   = TW'(CAP_DLY - 1);

  seq_state_e    st, nxt;
  logic          tmr_load, tmr_zero;
  logic [TW-1:0] tmr_val;

  step_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= nxt;
  end

  always_comb begin
    nxt      = st;
    tmr_load = 1'b0;
    tmr_val  = '0;
    cap      = 1'b0;
    unique case (st)
      ST_IDLE: if (start_ok) begin nxt = ST_CSET; tmr_load = 1'b1; tmr_val = L_SETUP; end
      ST_CSET: if (tmr_zero) nxt = ST_CSTB;
      ST_CSTB: begin nxt = ST_CHLD; tmr_load = 1'b1; tmr_val = L_HOLD; end
      ST_CHLD: if (tmr_zero) begin nxt = ST_ASET; tmr_load = 1'b1; tmr_val = L_SETUP; end
      ST_ASET: if (tmr_zero) nxt = ST_ASTB;
      ST_ASTB: begin nxt = ST_AHLD; tmr_load = 1'b1; tmr_val = L_HOLD; end
      ST_AHLD: if (tmr_zero) begin nxt = ST_GAP; tmr_load = 1'b1; tmr_val = L_GAP; end
      ST_GAP:  if (tmr_zero) begin nxt = ST_READ; tmr_load = 1'b1; tmr_val = L_CAP; end
      ST_READ: if (tmr_zero) begin nxt = ST_FIN; cap = 1'b1; end
      ST_FIN:  nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_comb begin
    busy     = (st != ST_IDLE);
    done     = (st == ST_FIN);
    ld_pulse = (st == ST_CSTB) || (st == ST_ASTB);
    rd_en_n  = (st != ST_READ);
    byte_sel = (st == ST_READ);
    bus_oe   = 1'b0;
    bus_out  = 8'h00;
    act_sel  = ACT_NONE;
    case (st)
      ST_CSET, ST_CSTB, ST_CHLD: begin
        bus_oe = 1'b1; bus_out = CMD_READ_CAL; act_sel = ACT_CMD;
      end
      ST_ASET, ST_ASTB, ST_AHLD: begin
        bus_oe = 1'b1; bus_out = ADDR_CAL_LO; act_sel = ACT_ADDR;
      end
      default: ;
    endcase
  end

  // R2, R3: strobe lasts one cycle
  a_r2_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    ld_pulse |=> !ld_pulse);
  // R10: strobe lands on a bus that was already driven (setup)
  a_r10_strobe_driven: assert property (@(posedge clk) disable iff (!rst_n)
    ld_pulse |-> (bus_oe && $past(bus_oe)));
  // R4: driver was off before read enable fell
  a_r4_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_en_n) |-> (!bus_oe && !$past(bus_oe)));
  // R6: done is a lone pulse, R5: read enable back high by then
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r5_oe_released: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rd_en_n && $past(!rd_en_n)));
endmodule

// File: rtl/calib_read_seq.sv
module calib_read_seq #(
  parameter int unsigned SETUP_CYC = 1,
  parameter int unsigned HOLD_CYC  = 1,
  parameter int unsigned GAP_CYC   = 1,
  parameter int unsigned CAP_DLY   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  output logic       busy,
  output logic       done,
  output logic       res_valid,
  input  logic       res_ready,
  output logic [7:0] res_data,
  output logic [1:0] act_sel,
  output logic       byte_sel,
  output logic       ld_pulse,
  output logic       rd_en_n,
  output logic [7:0] bus_out,
  output logic       bus_oe,
  input  logic [7:0] bus_in
);
  logic start_ok, cap;

  // R9: no new run while a result waits
  assign start_ok = start && !res_valid;

  seq_fsm #(
    .SETUP_CYC(SETUP_CYC), .HOLD_CYC(HOLD_CYC),
    .GAP_CYC(GAP_CYC), .CAP_DLY(CAP_DLY)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_ok(start_ok),
    .busy(busy), .done(done), .cap(cap),
    .act_sel(act_sel), .byte_sel(byte_sel), .ld_pulse(ld_pulse),
    .rd_en_n(rd_en_n), .bus_out(bus_out), .bus_oe(bus_oe)
  );

  cal_result #(.DW(8)) u_res (
    .clk(clk), .rst_n(rst_n), .cap(cap), .cap_data(bus_in),
    .res_ready(res_ready), .res_valid(res_valid), .res_data(res_data)
  );

  // R8: result appears together with done
  a_r8_valid_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> res_valid);
  // R9: pending result blocks a new run
  a_r9_no_start_full: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && res_valid) |=> !busy);
endmodule

// File: tb/sim_calib_read_seq.sv
module sim_calib_read_seq;
  localparam int S = 1, H = 1, G = 1, C = 2;
  localparam int K_CSTB = S + 1;
  localparam int K_ASET = K_CSTB + H + 1;
  localparam int K_ASTB = K_ASET + S;
  localparam int K_GAP  = K_ASTB + H + 1;
  localparam int K_READ = K_GAP + G;
  localparam int K_FIN  = K_READ + C;

  logic clk = 0, rst_n = 0, start = 0, res_ready = 1;
  logic busy, done, res_valid, byte_sel, ld_pulse, rd_en_n, bus_oe;
  logic [7:0] res_data, bus_out, bus_in, dev_val;
  logic [1:0] act_sel;
  int low_cnt;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  calib_read_seq #(.SETUP_CYC(S), .HOLD_CYC(H), .GAP_CYC(G), .CAP_DLY(C)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
    .act_sel(act_sel), .byte_sel(byte_sel), .ld_pulse(ld_pulse),
    .rd_en_n(rd_en_n), .bus_out(bus_out), .bus_oe(bus_oe), .bus_in(bus_in)
  );

  // target model: reply valid only from the C-th read cycle
  always @(posedge clk) low_cnt <= rd_en_n ? 0 : low_cnt + 1;
  assign bus_in = (!rd_en_n && low_cnt >= C - 1) ? dev_val : ~dev_val;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // {busy,done,ld,oe,rd_n,bs,act[1:0],bus[7:0],valid}
  function automatic logic [16:0] exp_obs(int k, bit rdy);
    if (k < K_CSTB)      return {6'b100110, 2'b10, 8'h08, 1'b0};
    else if (k == K_CSTB) return {6'b101110, 2'b10, 8'h08, 1'b0};
    else if (k < K_ASET) return {6'b100110, 2'b10, 8'h08, 1'b0};
    else if (k < K_ASTB) return {6'b100110, 2'b00, 8'h00, 1'b0};
    else if (k == K_ASTB) return {6'b101110, 2'b00, 8'h00, 1'b0};
    else if (k < K_GAP)  return {6'b100110, 2'b00, 8'h00, 1'b0};
    else if (k < K_READ) return {6'b100010, 2'b00, 8'h00, 1'b0};
    else if (k < K_FIN)  return {6'b100001, 2'b00, 8'h00, 1'b0};
    else if (k == K_FIN) return {6'b110010, 2'b00, 8'h00, 1'b1};
    else                 return {6'b000010, 2'b00, 8'h00, !rdy};
  endfunction

  function automatic string req_of(int k);
    if (k <= K_CSTB + H) return "R2";
    if (k < K_GAP)       return "R3";
    if (k < K_READ)      return "R4";
    if (k < K_FIN)       return "R5";
    return "R6";
  endfunction

  task automatic run_seq(input logic [7:0] dv, input bit rdy, input int stray_k);
    int nld = 0;
    dev_val = dv;
    res_ready = rdy;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    for (int k = 1; k <= K_FIN + 1; k++) begin
      chk(req_of(k), {15'd0, busy, done, ld_pulse, bus_oe, rd_en_n, byte_sel,
                      act_sel, bus_out, res_valid},
          {15'd0, exp_obs(k, rdy)});
      if (ld_pulse) nld++;
      if (k == K_FIN) chk("R8 data", {24'd0, res_data}, {24'd0, dv});
      if (k == stray_k) start = 1;
      @(negedge clk) start = 0;
    end
    chk("R10 strobes", nld, 2);
  endtask

  task automatic t_reset;
    chk("R1", {24'd0, ld_pulse, rd_en_n, bus_oe, busy, done, res_valid, act_sel},
        {24'd0, 8'b01000000});
    chk("R1 bus", {24'd0, bus_out, 1'b0, byte_sel}, 32'd0);
  endtask

  task automatic t_basic;
    run_seq(8'h5A, 1'b1, 0);
    run_seq(8'hC3, 1'b1, 0);
  endtask

  task automatic t_stray_busy;
    // R7: start raised in the command step and again during the read
    run_seq(8'h91, 1'b1, 3);
    run_seq(8'h17, 1'b1, K_READ);
  endtask

  task automatic t_backpressure;
    run_seq(8'hE4, 1'b0, 0);
    repeat (3) @(negedge clk);
    chk("R8 stall valid", {31'd0, res_valid}, 1);
    chk("R8 stall data", {24'd0, res_data}, {24'd0, 8'hE4});
    start = 1;
    @(negedge clk) start = 0;
    chk("R9 ignored start", {31'd0, busy}, 0);
    @(negedge clk);
    chk("R9 still idle", {30'd0, busy, ld_pulse}, 0);
    chk("R9 data kept", {24'd0, res_data}, {24'd0, 8'hE4});
    res_ready = 1;
    @(negedge clk);
    chk("R8 consumed", {31'd0, res_valid}, 0);
    run_seq(8'h00, 1'b1, 0);
    run_seq(8'hFF, 1'b1, 0);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    dev_val = 8'h00;
    #1 t_reset;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_basic;
    t_stray_busy;
    t_backpressure;
    finished = 1;
    summary;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary;
    end
  end
endmodule